// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block places a four-byte host window in front of a 15-bit internal byte address space that holds registers and buffer memory. The host side uses a single-cycle synchronous strobe: one access per asserted cycle, with offset, direction and write byte. Offset 0 always reaches the mode byte. With indirect mode selected, offsets 1 and 2 hold a big-endian pointer into the internal space, and offset 3 is a data port. A read or write at offset 3 becomes one access on the internal byte port at the pointer.

When the auto-advance mode bit is set, the pointer steps by one after every data port access, so a multi-byte register or a stretch of buffer can be streamed through offset 3. The step wraps only at the top of the whole 15-bit space and never at buffer region edges. Software handles those by reloading the pointer. Setting the soft-reset bit of the mode byte raises a reset pulse toward the internal register file for a fixed number of cycles. When the pulse ends, the mode byte and the pointer both return to zero.

The internal port reads combinationally: the data presented on `mem_rdata_i` during a data port read is returned on `host_rdata_o` in the same cycle.

Top module: `iwb_bridge`

## Requirements
- R1: After reset the mode byte reads 0x00, the pointer is 0x0000, and `core_rst_o`, `mem_req_o` and `ping_block_o` are low.
- R2: Offset 0 is writable and readable in every mode. A read returns the last value written, as long as no soft reset has completed since that write.
- R3: With indirect mode on, offset 1 writes pointer bits 14:8 from write bits 6:0 (bit 7 is dropped and reads back 0), and offset 2 writes pointer bits 7:0. Reads return those bytes. A pointer write causes no internal access.
- R4: With indirect mode on, a read at offset 3 asserts `mem_req_o` with `mem_we_o` low and `mem_addr_o` equal to the pointer in that cycle, and returns `mem_rdata_i` on `host_rdata_o` in the same cycle.
- R5: With indirect mode on, a write at offset 3 asserts `mem_req_o` and `mem_we_o` in that cycle, with the pointer on `mem_addr_o` and the host byte on `mem_wdata_o`.
- R6: With mode bit 1 set, the pointer advances by one after each data port access. With bit 1 clear, it holds its value.
- R7: Auto-advance passes through buffer region edges such as 0x5FFF to 0x6000 without change and wraps only from 0x7FFF to 0x0000.
- R8: With mode bit 0 clear, writes to offsets 1 to 3 are ignored, reads of them return 0x00, and no internal access occurs.
- R9: A mode write with bit 7 set raises `core_rst_o` from the next cycle for exactly RST_CYCLES cycles. In the first cycle after the pulse, the mode byte and the pointer read zero.
- R10: While `core_rst_o` is high, every host write is ignored, no internal access is made, and an offset 3 read returns 0x00.
- R11: `ping_block_o` equals mode bit 4.
- R12: With no strobe, or during a host write, `host_rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host access strobe, one cycle per access |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_off_i | input | 2 | Window offset: 0 mode, 1 pointer high, 2 pointer low, 3 data |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, valid in the strobe cycle |
| mem_req_o | output | 1 | Internal access strobe |
| mem_we_o | output | 1 | Internal write enable |
| mem_addr_o | output | 15 | Internal byte address (current pointer) |
| mem_wdata_o | output | 8 | Internal write byte |
| mem_rdata_i | input | 8 | Internal read byte, combinational |
| core_rst_o | output | 1 | Reset pulse to the internal register file |
| ping_block_o | output | 1 | Echo-reply suppression flag from the mode byte |

## Verification
Two pairs of functions can coincide. A data port access and a pointer step share one clock edge. A host strobe can also arrive while a soft-reset pulse is still counting down. The bench drives back-to-back offset 3 accesses with auto-advance on, including runs across 0x5FFF and 0x7FFF, so the access address and the next pointer value are judged in adjacent cycles. It then writes the reset bit and immediately issues data writes, pointer writes and mode writes inside the pulse. A reference model compares every cycle to confirm that none of them reaches the internal port or survives the pulse.

// File: rtl/iwb_pkg.sv
package iwb_pkg;
  typedef enum logic [1:0] {
    OFF_MODE    = 2'd0,
    OFF_ADDR_HI = 2'd1,
    OFF_ADDR_LO = 2'd2,
    OFF_DATA    = 2'd3
  } win_off_e;

  localparam int MB_SOFT_RST = 7;
  localparam int MB_PING_BLK = 4;
  localparam int MB_AUTO_INC = 1;
  localparam int MB_INDIRECT = 0;
endpackage

// File: rtl/iwb_mode_reg.sv
module iwb_mode_reg
  import iwb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mode_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [DATA_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cnt_q  <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) mode_q <= '0;
    end else if (wr_i) begin
      mode_q <= wdata_i;
      if (wdata_i[MB_SOFT_RST]) cnt_q <= CNT_W'(RST_CYCLES);
    end
  end

  assign mode_o = mode_q;
  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/iwb_addr_ptr.sv
module iwb_addr_ptr #(
  parameter int ADDR_W = 15,
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hi_we_i,
  input  logic              lo_we_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [7:0]        lo_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clr_i)   addr_q <= '0;
    else if (hi_we_i) addr_q[ADDR_W-1:8] <= hi_i;
    else if (lo_we_i) addr_q[7:0] <= lo_i;
    else if (inc_i)   addr_q <= addr_q + 1'b1; // natural wrap at 2^ADDR_W
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/iwb_bridge.sv
module iwb_bridge
  import iwb_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_we_i,
  input  logic [1:0]        host_off_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              core_rst_o,
  output logic              ping_block_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [DATA_W-1:0] mode_q;
  logic              busy, done, indirect, auto_inc;
  logic              wr_ok, data_acc;
  logic [ADDR_W-1:0] addr_q;
  win_off_e          off;

  assign off      = win_off_e'(host_off_i);
  assign indirect = mode_q[MB_INDIRECT];
  assign auto_inc = mode_q[MB_AUTO_INC];
  assign wr_ok    = host_sel_i && host_we_i && !busy;
  assign data_acc = host_sel_i && (off == OFF_DATA) && indirect && !busy;

  iwb_mode_reg #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ok && off == OFF_MODE),
    .wdata_i (host_wdata_i),
    .mode_o  (mode_q),
    .busy_o  (busy),
    .done_o  (done)
  );

  iwb_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (done),
    .hi_we_i (wr_ok && indirect && off == OFF_ADDR_HI),
    .lo_we_i (wr_ok && indirect && off == OFF_ADDR_LO),
    .hi_i    (host_wdata_i[HI_W-1:0]),
    .lo_i    (host_wdata_i[7:0]),
    .inc_i   (data_acc && auto_inc),
    .addr_o  (addr_q)
  );

  always_comb begin
    host_rdata_o = '0;
    if (host_sel_i && !host_we_i) begin
      unique case (off)
        OFF_MODE:    host_rdata_o = mode_q;
        OFF_ADDR_HI: if (indirect) host_rdata_o = DATA_W'(addr_q >> 8);
        OFF_ADDR_LO: if (indirect) host_rdata_o = DATA_W'(addr_q[7:0]);
        OFF_DATA:    if (data_acc) host_rdata_o = mem_rdata_i;
        default:     host_rdata_o = '0;
      endcase
    end
  end

  assign mem_req_o    = data_acc;
  assign mem_we_o     = data_acc && host_we_i;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = host_wdata_i;
  assign core_rst_o   = busy;
  assign ping_block_o = mode_q[MB_PING_BLK];
endmodule

// File: rtl/iwb_checker.sv
module iwb_checker #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_sel_i,
  input logic              host_we_i,
  input logic [1:0]        host_off_i,
  input logic              rst_bit_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              core_rst_o,
  input logic              ping_block_o,
  input logic              auto_inc_i
);
  AST_REQ_ONLY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (host_sel_i && host_off_i == 2'd3)); // R3
  AST_WE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && host_we_i)); // R5
  AST_RD_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> host_rdata_o == mem_rdata_i); // R4
  AST_AUTO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && auto_inc_i) ##1 mem_req_o |->
      mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)); // R6
  AST_NO_ACC_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> !mem_req_o); // R10
  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(host_sel_i && host_we_i && host_off_i == 2'd0 && rst_bit_i)); // R9
  AST_RST_CLEARS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> !ping_block_o); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_sel_i || host_we_i) |-> host_rdata_o == '0); // R12
endmodule

bind iwb_bridge iwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_iwb_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_sel_i   (host_sel_i),
  .host_we_i    (host_we_i),
  .host_off_i   (host_off_i),
  .rst_bit_i    (host_wdata_i[7]),
  .host_rdata_o (host_rdata_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rdata_i  (mem_rdata_i),
  .core_rst_o   (core_rst_o),
  .ping_block_o (ping_block_o),
  .auto_inc_i   (auto_inc)
);

// File: tb/iwb_bridge_tb_top.sv
`timescale 1ns/1ps
module iwb_bridge_tb_top;
  localparam int AW = 15;
  localparam int RC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [1:0] off = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd, mrd, mwd;
  logic       mreq, mwe, crst, pblk;
  logic [AW-1:0] maddr;

  logic [7:0] tb_mem [0:(1<<AW)-1];

  int vectors = 0;
  int errors  = 0;

  // behavioural reference state
  int m_mode = 0;
  int m_ptr  = 0;
  int m_cnt  = 0;

  always #4 clk = ~clk;

  assign mrd = tb_mem[maddr];

  iwb_bridge #(.ADDR_W(AW), .DATA_W(8), .RST_CYCLES(RC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_sel_i(sel), .host_we_i(we), .host_off_i(off), .host_wdata_i(wd),
    .host_rdata_o(rd),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .mem_rdata_i(mrd),
    .core_rst_o(crst), .ping_block_o(pblk)
  );

  task automatic chk(string req, string what, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one host cycle: drive, compare against model, then advance model
  task automatic cyc(bit s, bit w, int o, int d, string req);
    bit ind, busy, acc;
    int exp_rd;
    @(negedge clk);
    sel = s; we = w; off = o[1:0]; wd = d[7:0];
    #1;
    ind  = m_mode[0];
    busy = (m_cnt != 0);
    acc  = s && o == 3 && ind && !busy;
    exp_rd = 0;
    if (s && !w) begin
      case (o)
        0: exp_rd = m_mode;
        1: exp_rd = ind ? (m_ptr >> 8) : 0;
        2: exp_rd = ind ? (m_ptr & 8'hFF) : 0;
        default: exp_rd = acc ? int'(tb_mem[m_ptr]) : 0;
      endcase
    end
    vectors++;
    chk(req, "host_rdata", int'(rd), exp_rd);
    chk(req, "mem_req", int'(mreq), int'(acc));
    chk(req, "mem_we", int'(mwe), int'(acc && w));
    if (acc) chk(req, "mem_addr", int'(maddr), m_ptr);
    if (acc && w) chk(req, "mem_wdata", int'(mwd), d & 8'hFF);
    chk(req, "core_rst", int'(crst), int'(busy));
    chk(req, "ping_block", int'(pblk), (m_mode >> 4) & 1);
    @(posedge clk);
    if (mreq && mwe) tb_mem[maddr] = mwd;
    if (busy) begin
      m_cnt--;
      if (m_cnt == 0) begin m_mode = 0; m_ptr = 0; end
    end else if (s && w) begin
      if (o == 0) begin
        m_mode = d & 8'hFF;
        if (d & 8'h80) m_cnt = RC;
      end else if (o == 1 && ind) m_ptr = ((d & 8'h7F) << 8) | (m_ptr & 8'hFF);
      else if (o == 2 && ind) m_ptr = (m_ptr & 16'h7F00) | (d & 8'hFF);
    end
    if (acc && m_mode[1]) m_ptr = (m_ptr + 1) % (1 << AW);
  endtask

  task automatic idle(string req); cyc(0, 0, 0, 0, req); endtask
  task automatic wr(int o, int d, string req); cyc(1, 1, o, d, req); endtask
  task automatic rdc(int o, string req); cyc(1, 0, o, 0, req); endtask

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < (1 << AW); i++) tb_mem[i] = 8'((i * 37) ^ (i >> 8));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    idle("R1");
    rdc(0, "R1");
    // R8 direct mode: pointer/data offsets dead
    wr(1, 8'h22, "R8"); wr(2, 8'h33, "R8"); wr(3, 8'hAB, "R8");
    rdc(1, "R8"); rdc(2, "R8"); rdc(3, "R8");
    // R2 mode readback, R12 idle data
    wr(0, 8'h03, "R2"); rdc(0, "R2"); idle("R12"); wr(0, 8'h00, "R12");
    wr(0, 8'h03, "R2");
    // R3 pointer bytes, high bit 7 dropped, no internal access
    wr(1, 8'hFF, "R3"); rdc(1, "R3");
    wr(1, 8'h12, "R3"); wr(2, 8'h34, "R3"); rdc(1, "R3"); rdc(2, "R3");
    // R5 data writes with R6 stepping
    wr(3, 8'hA1, "R5"); wr(3, 8'hB2, "R5"); wr(3, 8'hC3, "R6");
    rdc(2, "R6");
    wr(1, 8'h12, "R3"); wr(2, 8'h34, "R3");
    // R4 back-to-back reads
    rdc(3, "R4"); rdc(3, "R4"); rdc(3, "R4"); rdc(3, "R4");
    // R6 no stepping with bit 1 clear
    wr(0, 8'h01, "R6"); wr(2, 8'h40, "R6");
    rdc(3, "R6"); rdc(3, "R6"); wr(3, 8'h5C, "R6"); rdc(3, "R6"); rdc(2, "R6");
    // R7 region edge and top wrap
    wr(0, 8'h03, "R7"); wr(1, 8'h5F, "R7"); wr(2, 8'hFE, "R7");
    rdc(3, "R7"); rdc(3, "R7"); rdc(3, "R7"); rdc(1, "R7"); rdc(2, "R7");
    wr(1, 8'h7F, "R7"); wr(2, 8'hFF, "R7");
    wr(3, 8'h99, "R7"); rdc(1, "R7"); rdc(2, "R7"); rdc(3, "R7");
    // R11 ping flag
    wr(0, 8'h13, "R11"); idle("R11"); wr(0, 8'h03, "R11"); idle("R11");
    // R9/R10 soft reset with collisions inside the pulse
    wr(1, 8'h05, "R9"); wr(2, 8'h06, "R9");
    wr(0, 8'h93, "R9");
    wr(3, 8'hEE, "R10"); wr(0, 8'h13, "R10"); rdc(3, "R10");
    rdc(0, "R9"); rdc(1, "R9");
    wr(0, 8'h01, "R9"); rdc(1, "R9"); rdc(2, "R9");
    // R9 back-to-back soft reset, ending in direct mode
    wr(0, 8'h80, "R9"); idle("R9"); wr(1, 8'h11, "R10"); idle("R9"); rdc(0, "R9");
    repeat (2) idle("R1");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule